// File: doc/BRIEF.md
# Vector Destination Element Merge Unit

This unit builds the final value written back to one 128-bit vector destination register. It receives the freshly computed result, the previous contents of the destination, a per-element mask, the active vector length, the selected element width code, and two policy bits. One governs tail elements and one governs masked-off elements. Every element is sorted into one of three classes: active body, inactive body (masked off), or tail (index at or past the vector length). It then takes the new data, the old data, or an all-ones fill for that element.

Element boundaries follow the runtime width code, so one register holds sixteen 8-bit, eight 16-bit, four 32-bit or two 64-bit elements. Agnostic handling always writes all ones. This gives repeatable results that a verification flow can compare. The merge logic is combinational. The merged word, an error flag and a valid flag are registered, so results appear one cycle after the input strobe.

Top module: `vec_merge_unit`

## Requirements
- R1: While rst_ni is low, valid_o and err_o are 0 and data_o is all zeros.
- R2: valid_o equals valid_i of the previous cycle. data_o and err_o update only on a cycle after valid_i was 1. When valid_i is 0, data_o keeps its value on the next cycle.
- R3: The width code on sew_i selects the element size: 000 selects 8 bits, 001 selects 16, 010 selects 32 and 011 selects 64. Element e occupies bits [e*size +: size], with element 0 in the least significant bits.
- R4: An active body element takes its bits from result_i.
- R5: In a masked operation (masked_op_i = 1), body element e is inactive when mask_i[e] is 0. It then takes old_i when mask_pol_i is 0 and all ones when mask_pol_i is 1. Mask bits at or above the element count are ignored.
- R6: When masked_op_i is 0, mask_i has no effect and every body element is active.
- R7: An element with index e >= vl_i is tail, whatever its mask bit. It takes old_i when tail_pol_i is 0 and all ones when tail_pol_i is 1.
- R8: vl_i = 0 makes every element tail. Any vl_i at or above the element count leaves no tail.
- R9: A width code with bit 2 set is reserved. It yields data_o = old_i and err_o = 1. A legal code yields err_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input strobe |
| result_i | input | VLEN | Computed result data |
| old_i | input | VLEN | Previous destination contents |
| mask_i | input | VLEN/8 | Per-element mask, bit e for element e |
| masked_op_i | input | 1 | 1 when the operation is masked |
| vl_i | input | VL_W | Active vector length in elements |
| sew_i | input | 3 | Element width code |
| tail_pol_i | input | 1 | 1 selects agnostic tail handling |
| mask_pol_i | input | 1 | 1 selects agnostic masked-off handling |
| valid_o | output | 1 | Result valid |
| data_o | output | VLEN | Merged destination value |
| err_o | output | 1 | Reserved width code seen |

## Verification
Each merged word, its error flag and its valid flag are due exactly one clock edge after the strobe that carried the inputs. The bench drives on the falling edge. A behavioural model updates its expected outputs on the rising edge from the same inputs, and the bench compares on the next falling edge. Cycles with the strobe low are compared the same way, which confirms that the output word holds and valid drops.

// File: rtl/vmu_pkg.sv
package vmu_pkg;
  localparam int unsigned SHIFT_W = 2;

  typedef enum logic [1:0] {
    CLS_ACTIVE   = 2'd0,
    CLS_INACTIVE = 2'd1,
    CLS_TAIL     = 2'd2
  } elem_cls_e;
endpackage

// File: rtl/vmu_sew_decode.sv
module vmu_sew_decode
  import vmu_pkg::*;
(
  input  logic [2:0]         sew_i,
  output logic [SHIFT_W-1:0] shift_o,
  output logic               rsvd_o
);
  // byte-to-element shift: log2(element bytes)
  always_comb begin
    rsvd_o  = sew_i[2];
    shift_o = sew_i[SHIFT_W-1:0];
  end
endmodule

// File: rtl/vmu_byte_class.sv
module vmu_byte_class
  import vmu_pkg::*;
#(
  parameter int unsigned NBYTES = 16,
  parameter int unsigned VL_W   = 8,
  localparam int unsigned IDX_W = $clog2(NBYTES)
) (
  input  logic [SHIFT_W-1:0]         shift_i,
  input  logic [VL_W-1:0]            vl_i,
  input  logic [NBYTES-1:0]          mask_i,
  input  logic                       masked_op_i,
  output elem_cls_e [NBYTES-1:0]     cls_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    localparam logic [IDX_W-1:0] BIDX = IDX_W'(b);
    logic [IDX_W-1:0] elem_idx;
    logic [VL_W-1:0]  elem_ext;

    always_comb begin
      elem_idx = BIDX >> shift_i;
      elem_ext = '0;
      elem_ext[IDX_W-1:0] = elem_idx;
      // tail outranks mask
      if (elem_ext >= vl_i)                        cls_o[b] = CLS_TAIL;
      else if (masked_op_i && !mask_i[elem_idx])   cls_o[b] = CLS_INACTIVE;
      else                                         cls_o[b] = CLS_ACTIVE;
    end
  end
endmodule

// File: rtl/vmu_byte_select.sv
module vmu_byte_select
  import vmu_pkg::*;
#(
  parameter int unsigned NBYTES = 16
) (
  input  elem_cls_e [NBYTES-1:0]  cls_i,
  input  logic [NBYTES*8-1:0]     result_i,
  input  logic [NBYTES*8-1:0]     old_i,
  input  logic                    tail_pol_i,
  input  logic                    mask_pol_i,
  input  logic                    rsvd_i,
  output logic [NBYTES*8-1:0]     data_o
);
  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_comb begin
      if (rsvd_i) data_o[b*8 +: 8] = old_i[b*8 +: 8];
      else begin
        unique case (cls_i[b])
          CLS_ACTIVE:   data_o[b*8 +: 8] = result_i[b*8 +: 8];
          CLS_INACTIVE: data_o[b*8 +: 8] = mask_pol_i ? 8'hFF : old_i[b*8 +: 8];
          default:      data_o[b*8 +: 8] = tail_pol_i ? 8'hFF : old_i[b*8 +: 8];
        endcase
      end
    end
  end
endmodule

// File: rtl/vec_merge_unit.sv
module vec_merge_unit
  import vmu_pkg::*;
#(
  parameter int unsigned VLEN = 128,
  parameter int unsigned VL_W = 8,
  localparam int unsigned NBYTES = VLEN / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [VLEN-1:0]   result_i,
  input  logic [VLEN-1:0]   old_i,
  input  logic [NBYTES-1:0] mask_i,
  input  logic              masked_op_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [2:0]        sew_i,
  input  logic              tail_pol_i,
  input  logic              mask_pol_i,
  output logic              valid_o,
  output logic [VLEN-1:0]   data_o,
  output logic              err_o
);
  logic [SHIFT_W-1:0]     shift;
  logic                   rsvd;
  elem_cls_e [NBYTES-1:0] cls;
  logic [VLEN-1:0]        merged;
  logic                   valid_q, err_q;
  logic [VLEN-1:0]        data_q;

  vmu_sew_decode u_dec (
    .sew_i   (sew_i),
    .shift_o (shift),
    .rsvd_o  (rsvd)
  );

  vmu_byte_class #(.NBYTES(NBYTES), .VL_W(VL_W)) u_cls (
    .shift_i     (shift),
    .vl_i        (vl_i),
    .mask_i      (mask_i),
    .masked_op_i (masked_op_i),
    .cls_o       (cls)
  );

  vmu_byte_select #(.NBYTES(NBYTES)) u_sel (
    .cls_i      (cls),
    .result_i   (result_i),
    .old_i      (old_i),
    .tail_pol_i (tail_pol_i),
    .mask_pol_i (mask_pol_i),
    .rsvd_i     (rsvd),
    .data_o     (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_i;
      err_q   <= valid_i & rsvd;
      if (valid_i) data_q <= merged;
    end
  end

  assign valid_o = valid_q;
  assign err_o   = err_q;
  assign data_o  = data_q;

  a_r2_err_needs_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> valid_o);
  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o));
  a_r9_rsvd_keeps_old: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sew_i[2]) |=> (err_o && data_o == $past(old_i)));
  a_r8_vl0_tail_undisturbed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sew_i[2] && vl_i == '0 && !tail_pol_i) |=> data_o == $past(old_i));
  a_r7_vl0_tail_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sew_i[2] && vl_i == '0 && tail_pol_i) |=> data_o == '1);
  a_r6_unmasked_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !sew_i[2] && !masked_op_i && vl_i >= VL_W'(NBYTES)) |=> data_o == $past(result_i));
endmodule

// File: tb/sim_vec_merge_unit.sv
module sim_vec_merge_unit;
  localparam int VLEN = 128;
  localparam int NB   = VLEN / 8;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic [VLEN-1:0] result_i = '0, old_i = '0;
  logic [NB-1:0] mask_i = '0;
  logic masked_op_i = 1'b0;
  logic [7:0] vl_i = '0;
  logic [2:0] sew_i = '0;
  logic tail_pol_i = 1'b0, mask_pol_i = 1'b0;
  logic valid_o, err_o;
  logic [VLEN-1:0] data_o;

  int checks = 0, fails = 0;
  logic exp_valid, exp_err;
  logic [VLEN-1:0] exp_data;

  always #4 clk_i = ~clk_i;

  vec_merge_unit u0 (
    .clk_i, .rst_ni, .valid_i, .result_i, .old_i, .mask_i, .masked_op_i,
    .vl_i, .sew_i, .tail_pol_i, .mask_pol_i, .valid_o, .data_o, .err_o
  );

  function automatic logic [VLEN-1:0] ref_merge(
      logic [VLEN-1:0] res, logic [VLEN-1:0] old, logic [NB-1:0] msk,
      logic mop, int vl, logic [2:0] sew, logic ta, logic ma);
    logic [VLEN-1:0] r;
    int esz, n;
    r = old;
    if (sew[2]) return r;
    esz = 8 << sew[1:0];
    n = VLEN / esz;
    for (int e = 0; e < n; e++) begin
      for (int k = 0; k < esz; k++) begin
        if (e >= vl)               r[e*esz+k] = ta ? 1'b1 : old[e*esz+k];
        else if (mop && !msk[e])   r[e*esz+k] = ma ? 1'b1 : old[e*esz+k];
        else                       r[e*esz+k] = res[e*esz+k];
      end
    end
    return r;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_valid <= 1'b0; exp_err <= 1'b0; exp_data <= '0;
    end else begin
      exp_valid <= valid_i;
      exp_err   <= valid_i && sew_i[2];
      if (valid_i)
        exp_data <= ref_merge(result_i, old_i, mask_i, masked_op_i, int'(vl_i),
                              sew_i, tail_pol_i, mask_pol_i);
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  task automatic compare(string tag);
    checks += 3;
    if (valid_o !== exp_valid) begin
      fails++; $display("FAIL %s valid_o act=%b exp=%b", tag, valid_o, exp_valid);
    end
    if (err_o !== exp_err) begin
      fails++; $display("FAIL %s err_o act=%b exp=%b", tag, err_o, exp_err);
    end
    if (data_o !== exp_data) begin
      fails++; $display("FAIL %s data_o act=%h exp=%h", tag, data_o, exp_data);
    end
  endtask

  // called at a falling edge; result compared on the next falling edge
  task automatic step(logic v, logic [VLEN-1:0] res, logic [VLEN-1:0] old,
                      logic [NB-1:0] msk, logic mop, logic [7:0] vl,
                      logic [2:0] sew, logic ta, logic ma, string tag);
    valid_i = v; result_i = res; old_i = old; mask_i = msk; masked_op_i = mop;
    vl_i = vl; sew_i = sew; tail_pol_i = ta; mask_pol_i = ma;
    @(negedge clk_i);
    compare(tag);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog act=timeout exp=done");
    summary();
  end

  localparam logic [VLEN-1:0] RA = 128'h0123456789abcdef_fedcba9876543210;
  localparam logic [VLEN-1:0] OA = 128'h5a5a5a5a_3c3c3c3c_a5a5a5a5_c3c3c3c3;

  initial begin
    valid_i = 1'b1; vl_i = 8'd16;
    repeat (2) @(negedge clk_i);
    checks += 3;  // R1 reset state, with valid_i high
    if (valid_o !== 1'b0) begin fails++; $display("FAIL R1 valid_o act=%b exp=0", valid_o); end
    if (err_o   !== 1'b0) begin fails++; $display("FAIL R1 err_o act=%b exp=0", err_o); end
    if (data_o  !== '0)   begin fails++; $display("FAIL R1 data_o act=%h exp=0", data_o); end
    valid_i = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R4 R8 unmasked, full length, 8-bit
    step(1, RA, OA, '0, 0, 8'd16, 3'b000, 0, 0, "R4");
    // R3 16-bit, vl 3, tail undisturbed
    step(1, RA, OA, '1, 1, 8'd3, 3'b001, 0, 0, "R3");
    // R7 32-bit, tail agnostic
    step(1, RA, OA, '1, 1, 8'd2, 3'b010, 1, 0, "R7");
    // R5 64-bit, element 1 masked off, undisturbed
    step(1, RA, OA, 16'h0001, 1, 8'd2, 3'b011, 0, 0, "R5");
    // R5 8-bit, mask agnostic
    step(1, RA, OA, 16'hA5A5, 1, 8'd16, 3'b000, 0, 1, "R5");
    // R5 bits above element count ignored
    step(1, RA, OA, 16'hFFFC, 1, 8'd2, 3'b011, 0, 1, "R5");
    // R6 unmasked with zero mask
    step(1, RA, OA, '0, 0, 8'd8, 3'b001, 1, 1, "R6");
    // R7 tail wins over mask
    step(1, RA, OA, '0, 1, 8'd1, 3'b000, 1, 0, "R7");
    // R8 vl zero and large vl
    step(1, RA, OA, '1, 1, 8'd0, 3'b010, 0, 1, "R8");
    step(1, RA, OA, '1, 1, 8'd0, 3'b000, 1, 0, "R8");
    step(1, RA, OA, '1, 0, 8'd200, 3'b011, 1, 1, "R8");
    // R9 reserved codes
    step(1, RA, OA, '1, 0, 8'd16, 3'b101, 1, 1, "R9");
    step(1, RA, ~OA, '0, 1, 8'd0, 3'b111, 1, 1, "R9");
    // R2 idle cycles hold data
    step(0, ~RA, ~OA, '0, 0, 8'd0, 3'b000, 1, 1, "R2");
    step(0, RA, OA, '1, 1, 8'd4, 3'b001, 0, 0, "R2");
    step(1, RA, OA, 16'h00F0, 1, 8'd12, 3'b000, 1, 0, "R2");
    for (int i = 0; i < 60; i++) begin
      step(($urandom % 4) != 0, {$urandom, $urandom, $urandom, $urandom},
           {$urandom, $urandom, $urandom, $urandom}, NB'($urandom), 1'($urandom),
           8'($urandom % 20), 3'($urandom % 5), 1'($urandom), 1'($urandom), "R3");
    end
    summary();
  end
endmodule